// File: doc/BRIEF.md
# Configuration Request Retry Engine

This block sits between a root-side port that raises configuration reads and writes and the link-side transaction interface that carries them to a device. It accepts one request at a time, issues it, and looks at the status of the completion that comes back. A completion that reports Configuration Request Retry Status (CRS) causes the same request to be sent again as a new request. Each new attempt waits a fixed number of microsecond ticks after the previous one. Retrying ends when a normal completion arrives, when an error completion arrives, or when an overall budget of microsecond ticks runs out. That budget is counted from the moment the request is accepted.

One case skips the retry loop. If the software-visibility enable input is high, a read of the dword that holds the Vendor ID gets a made-up answer instead of a retry. The upper halfword of that answer is all ones and the low halfword is 0x0001. For byte and halfword reads, the block also picks the addressed lanes out of the returned dword. The caller therefore receives right-aligned data together with a one-cycle done pulse and an error flag.

Top module: `cfg_retry_engine`

## Requirements
- R1: A read that gets a successful completion (status 0) ends with done, the error flag low, and the completion data. Exactly one request is sent on the link side.
- R2: A CRS completion (status 2) to a write, or to a read outside dword 0 (address bits above bit 1 not all zero), causes the same request to be sent again. The address, direction and write data are unchanged.
- R3: When crs_sv_en is high and a read of dword 0 gets CRS, the block finishes without sending the request again. The dword it returns is 0xFFFF0001, shaped by the read size, and the error flag is low.
- R4: When crs_sv_en is low, a read of dword 0 that gets CRS is sent again like any other request.
- R5: Between a CRS completion and the next attempt of the same request, exactly GAP_US microsecond ticks are counted.
- R6: If a CRS completion arrives after TIMEOUT_US ticks have passed since the request was accepted, a read ends with 0xFFFFFFFF and the error flag high. The same applies if the budget runs out during the gap between attempts.
- R7: req_size selects the read width: 0 is a byte, 1 is a halfword, 2 or 3 is a dword. A byte or halfword read returns the completion dword shifted right by 8 times req_addr[1:0], then masked to 8 or 16 bits.
- R8: A write that runs out of budget ends with the error flag high and done_rdata equal to zero.
- R9: A completion with status 1 (unsupported request) or 4 (completer abort) ends the request at once, with the error flag high. Any other status that is not 0 or 2 is handled the same way. A read then returns 0xFFFFFFFF and a write returns zero.
- R10: busy rises in the cycle after acceptance and stays high up to and including the done cycle. A req_valid seen while busy is ignored: it causes no extra link request and no extra done.
- R11: The timeout budget is not restarted between attempts, so a device that answers CRS forever still ends the request.
- R12: done is high for exactly one clock cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| crs_sv_en | input | 1 | Software visibility of CRS for Vendor ID reads |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address in configuration space |
| req_size | input | 2 | Read width: 0 byte, 1 halfword, 2/3 dword |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error or timeout, valid with done |
| done_rdata | output | 32 | Right-aligned read data, valid with done |
| tx_valid | output | 1 | One-cycle issue strobe to the link side |
| tx_write | output | 1 | Direction of the issued request |
| tx_addr | output | ADDR_W | Address of the issued request |
| tx_wdata | output | 32 | Write data of the issued request |
| cpl_valid | input | 1 | Completion strobe from the link side |
| cpl_status | input | 3 | Completion status: 0 ok, 1 UR, 2 CRS, 4 CA |
| cpl_data | input | 32 | Completion dword |

## Verification
The assertions run on every cycle and cover the following:
- the handshake shape: busy is held until done, done is a single-cycle pulse, and a link request is a single-cycle strobe;
- the outcome of each completion event: a CRS that will be retried does not finish the request, the Vendor ID shortcut finishes without an error, and an expired CRS or an error status finishes with the error flag set.

Other properties can only be shown by the bench scenarios, which compare results against a reference model:
- the exact tick spacing between attempts;
- the number of attempts;
- the returned data, including byte-lane shaping;
- the fact that the overall budget survives across reissues.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;

  localparam logic [2:0] CPL_OK  = 3'd0;
  localparam logic [2:0] CPL_UR  = 3'd1;
  localparam logic [2:0] CPL_CRS = 3'd2;
  localparam logic [2:0] CPL_CA  = 3'd4;

  localparam logic [31:0] VID_RETRY_WORD = 32'hFFFF_0001;
  localparam logic [31:0] FAIL_WORD      = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP,
    ST_DONE
  } eng_state_e;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] wdata;
  } req_info_t;

  // Right-align the addressed lanes of a dword for a sized read.
  function automatic logic [31:0] shape_read(input logic [31:0] dw,
                                             input logic [1:0]  lane,
                                             input logic [1:0]  sz);
    logic [31:0] moved;
    moved = dw >> {lane, 3'b000};
    case (sz)
      2'd0:    return {24'd0, moved[7:0]};
      2'd1:    return {16'd0, moved[15:0]};
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/cfg_tick_counter.sv
module cfg_tick_counter #(
  parameter int LIMIT = 1,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic reached
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en && tick && !reached) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign reached = (cnt >= CW'(LIMIT));

endmodule

// File: rtl/cfg_read_shaper.sv
module cfg_read_shaper
  import cfg_retry_pkg::*;
(
  input  logic [31:0] dword_in,
  input  logic [1:0]  lane,
  input  logic [1:0]  size,
  output logic [31:0] data_out
);

  always_comb data_out = shape_read(dword_in, lane, size);

endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfg_retry_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int GAP_US     = 1,
  parameter int TIMEOUT_US = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              crs_sv_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [31:0]       done_rdata,
  output logic              tx_valid,
  output logic              tx_write,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [31:0]       tx_wdata,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_status,
  input  logic [31:0]       cpl_data
);

  localparam int DW_BITS = ADDR_W - 2;

  eng_state_e        st, st_nx;
  logic [ADDR_W-1:0] addr_q;
  req_info_t         info_q;

  // Named internal events, observed by the bound checker.
  logic accept, in_wait, in_gap, in_flight;
  logic crs_hit, ok_hit, err_hit;
  logic vid_read, vid_shortcut, retry_start, give_up, finish;
  logic tmo_expired, gap_done;
  logic [31:0] shape_src, shaped;
  logic [31:0] res_d;
  logic        err_d;

  assign accept    = req_valid && (st == ST_IDLE);
  assign in_wait   = (st == ST_WAIT);
  assign in_gap    = (st == ST_GAP);
  assign in_flight = (st == ST_ISSUE) || in_wait || in_gap;

  assign crs_hit = in_wait && cpl_valid && (cpl_status == CPL_CRS);
  assign ok_hit  = in_wait && cpl_valid && (cpl_status == CPL_OK);
  assign err_hit = in_wait && cpl_valid && !crs_hit && !ok_hit;

  assign vid_read     = !info_q.wr && (addr_q[ADDR_W-1:2] == DW_BITS'(0));
  assign vid_shortcut = crs_hit && crs_sv_en && vid_read;
  assign retry_start  = crs_hit && !vid_shortcut && !tmo_expired;
  assign give_up      = (crs_hit && !vid_shortcut && tmo_expired) ||
                        (in_gap && tmo_expired);
  assign finish       = ok_hit || vid_shortcut || err_hit || give_up;

  // Overall budget: cleared once at acceptance, never between attempts.
  cfg_tick_counter #(.LIMIT(TIMEOUT_US)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .en      (in_flight),
    .tick    (us_tick),
    .reached (tmo_expired)
  );

  // Inter-attempt spacing: counts only while waiting to reissue.
  cfg_tick_counter #(.LIMIT(GAP_US)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!in_gap),
    .en      (in_gap),
    .tick    (us_tick),
    .reached (gap_done)
  );

  assign shape_src = vid_shortcut ? VID_RETRY_WORD : cpl_data;

  cfg_read_shaper u_shape (
    .dword_in (shape_src),
    .lane     (addr_q[1:0]),
    .size     (info_q.sz),
    .data_out (shaped)
  );

  always_comb begin
    if (ok_hit || vid_shortcut) begin
      err_d = 1'b0;
      res_d = info_q.wr ? 32'd0 : shaped;
    end else begin
      err_d = 1'b1;
      res_d = info_q.wr ? 32'd0 : FAIL_WORD;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (accept) st_nx = ST_ISSUE;
      ST_ISSUE: st_nx = ST_WAIT;
      ST_WAIT: begin
        if (finish)           st_nx = ST_DONE;
        else if (retry_start) st_nx = ST_GAP;
      end
      ST_GAP: begin
        if (finish)        st_nx = ST_DONE;
        else if (gap_done) st_nx = ST_ISSUE;
      end
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      info_q <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        addr_q       <= req_addr;
        info_q.wr    <= req_write;
        info_q.sz    <= req_size;
        info_q.wdata <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_rdata <= '0;
      done_err   <= 1'b0;
    end else if (finish) begin
      done_rdata <= res_d;
      done_err   <= err_d;
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);
  assign tx_valid = (st == ST_ISSUE);
  assign tx_write = info_q.wr;
  assign tx_addr  = addr_q;
  assign tx_wdata = info_q.wdata;

endmodule

// File: rtl/cfg_retry_engine_chk.sv
module cfg_retry_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       done_err,
  input logic       tx_valid,
  input logic       crs_hit,
  input logic       vid_shortcut,
  input logic       retry_start,
  input logic       tmo_expired,
  input logic       in_wait,
  input logic       cpl_valid,
  input logic [2:0] cpl_status
);

  assert_crs_reissue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retry_start |=> (busy && !done));

  assert_vid_no_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vid_shortcut |=> (done && !done_err));

  assert_budget_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_hit && !vid_shortcut && tmo_expired) |=> (done && done_err));

  assert_err_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && cpl_valid && (cpl_status == 3'd1 || cpl_status == 3'd4))
      |=> (done && done_err));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_tx_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind cfg_retry_engine cfg_retry_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .done_err     (done_err),
  .tx_valid     (tx_valid),
  .crs_hit      (crs_hit),
  .vid_shortcut (vid_shortcut),
  .retry_start  (retry_start),
  .tmo_expired  (tmo_expired),
  .in_wait      (in_wait),
  .cpl_valid    (cpl_valid),
  .cpl_status   (cpl_status)
);

// File: tb/test_cfg_retry_engine.sv
`timescale 1ns/1ps
module test_cfg_retry_engine;

  localparam int AW       = 12;
  localparam int GAP      = 2;
  localparam int TMO      = 40;
  localparam int TICK_DIV = 4;
  localparam int LAT      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic crs_sv_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic busy, done, done_err, tx_valid, tx_write;
  logic [31:0] done_rdata, tx_wdata;
  logic [AW-1:0] tx_addr;
  logic cpl_valid = 1'b0;
  logic [2:0] cpl_status = 3'd0;
  logic [31:0] cpl_data = '0;

  always #4 clk = ~clk;

  cfg_retry_engine #(.ADDR_W(AW), .GAP_US(GAP), .TIMEOUT_US(TMO)) i_cfg_retry_engine (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .crs_sv_en(crs_sv_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .done(done), .done_err(done_err), .done_rdata(done_rdata),
    .tx_valid(tx_valid), .tx_write(tx_write), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Completer script and bench-side expectations.
  int          n_crs = 0;
  logic [2:0]  fin_status = 3'd0;
  int          resp_idx = 0;
  int          issues = 0;
  int          lat_cnt = 0;
  bit          last_crs = 1'b0;
  int          tick_cnt = 0;
  int          tick_at_crs = 0;
  logic [AW-1:0] exp_addr = '0;
  bit          exp_wr = 1'b0;
  logic [31:0] exp_wd = '0;

  function automatic logic [31:0] mem_word(input int a);
    int d;
    d = a / 4;
    return {8'h5A, d[7:0], 8'hC3, d[7:0] ^ 8'h3C};
  endfunction

  // Link-side completer and microsecond tick, driven at the falling edge.
  initial begin
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      if (tx_valid) begin
        if (issues > 0 && last_crs)
          chk((tick_cnt - tick_at_crs) == GAP, "R5 ticks between attempts",
              32'(tick_cnt - tick_at_crs), 32'(GAP));
        chk(tx_addr == exp_addr && tx_write == exp_wr && (!exp_wr || tx_wdata == exp_wd),
            "R2 reissued request unchanged", {20'd0, tx_addr}, {20'd0, exp_addr});
        issues++;
        lat_cnt = LAT;
      end
      phase = (phase + 1) % TICK_DIV;
      us_tick = (phase == 0);
      if (us_tick) tick_cnt++;
      cpl_valid = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          cpl_valid  = 1'b1;
          last_crs   = (resp_idx < n_crs);
          cpl_status = last_crs ? 3'd2 : fin_status;
          cpl_data   = last_crs ? 32'hDEAD_BEEF : mem_word(int'(exp_addr));
          if (last_crs) tick_at_crs = tick_cnt;
          resp_idx++;
        end
      end
    end
  end

  // Reference model of busy/done, compared on every clock.
  bit          exp_busy = 1'b0;
  bit          last_done = 1'b0;
  int          done_cnt = 0;
  logic [31:0] got_rd;
  bit          got_err;

  initial begin
    bit r;
    bit acc;
    forever begin
      @(posedge clk);
      r = req_valid;
      #1;
      if (rst_n) begin
        acc = r && !exp_busy;
        if (acc) exp_busy = 1'b1;
        else if (last_done) exp_busy = 1'b0;
        chk(busy == exp_busy, "R10 busy vs model", {31'd0, busy}, {31'd0, exp_busy});
        if (done) begin
          chk(!last_done, "R12 done lasts one cycle", 32'd1, 32'd0);
          got_rd  = done_rdata;
          got_err = done_err;
          done_cnt++;
        end
        last_done = done;
      end
    end
  end

  task automatic run_txn(input bit wr, input int addr, input int sz, input logic [31:0] wd,
                         input int ncrs, input logic [2:0] fin, input bit sv,
                         input logic [31:0] edata, input bit eerr, input int eiss,
                         input bit poke, input string tag);
    int dc;
    int guard;
    @(negedge clk);
    n_crs = ncrs; fin_status = fin; resp_idx = 0; issues = 0; last_crs = 1'b0;
    exp_addr = AW'(addr); exp_wr = wr; exp_wd = wd;
    crs_sv_en = sv;
    req_write = wr; req_addr = AW'(addr); req_size = 2'(sz); req_wdata = wd;
    req_valid = 1'b1;
    dc = done_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_addr = AW'(addr + 12); req_write = ~wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (done_cnt == dc && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_cnt == dc + 1, {tag, " done seen"}, 32'(done_cnt - dc), 32'd1);
    chk(got_rd == edata, {tag, " data"}, got_rd, edata);
    chk(got_err == eerr, {tag, " error flag"}, {31'd0, got_err}, {31'd0, eerr});
    if (eiss >= 0) chk(issues == eiss, {tag, " attempts"}, 32'(issues), 32'(eiss));
    else           chk(issues >= 2, {tag, " attempts"}, 32'(issues), 32'd2);
    repeat (20) @(negedge clk);
    chk(done_cnt == dc + 1 && !busy, {tag, " no extra done"}, 32'(done_cnt - dc), 32'd1);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !tx_valid, "R10 reset state", {29'd0, busy, done, tx_valid}, 32'd0);

    m = mem_word(32'h40);
    run_txn(0, 32'h40, 2, 0, 0, 3'd0, 0, m, 0, 1, 0, "R1 plain read");
    run_txn(0, 32'h08, 2, 0, 3, 3'd0, 0, mem_word(8), 0, 4, 0, "R2 read CRS x3");
    run_txn(1, 32'h10, 2, 32'h1234_5678, 2, 3'd0, 0, 32'd0, 0, 3, 0, "R2 write CRS x2");
    run_txn(0, 32'h00, 2, 0, 5, 3'd0, 1, 32'hFFFF_0001, 0, 1, 0, "R3 vendor dword");
    run_txn(0, 32'h00, 1, 0, 5, 3'd0, 1, 32'h0000_0001, 0, 1, 0, "R3 vendor halfword");
    run_txn(0, 32'h02, 1, 0, 5, 3'd0, 1, 32'h0000_FFFF, 0, 1, 0, "R3 upper halfword");
    run_txn(0, 32'h20, 2, 0, 4, 3'd0, 1, mem_word(32'h20), 0, 5, 0, "R2 sv on other offset");
    run_txn(0, 32'h00, 2, 0, 2, 3'd0, 0, mem_word(0), 0, 3, 0, "R4 vendor sv off");
    m = mem_word(32'h0D);
    run_txn(0, 32'h0D, 0, 0, 1, 3'd0, 0, (m >> 8) & 32'hFF, 0, 2, 0, "R7 byte lane 1");
    m = mem_word(32'h13);
    run_txn(0, 32'h13, 0, 0, 0, 3'd0, 0, (m >> 24) & 32'hFF, 0, 1, 0, "R7 byte lane 3");
    m = mem_word(32'h12);
    run_txn(0, 32'h12, 1, 0, 0, 3'd0, 0, (m >> 16) & 32'hFFFF, 0, 1, 0, "R7 halfword hi");
    run_txn(0, 32'h30, 2, 0, 100000, 3'd0, 0, 32'hFFFF_FFFF, 1, -1, 0, "R6 R11 read timeout");
    run_txn(1, 32'h34, 2, 32'hCAFE_0000, 100000, 3'd0, 0, 32'd0, 1, -1, 0, "R8 write timeout");
    run_txn(0, 32'h44, 2, 0, 0, 3'd1, 0, 32'hFFFF_FFFF, 1, 1, 0, "R9 read UR");
    run_txn(1, 32'h48, 2, 32'h0BAD_F00D, 1, 3'd4, 0, 32'd0, 1, 2, 0, "R9 write CA after CRS");
    run_txn(0, 32'h50, 2, 0, 3, 3'd0, 0, mem_word(32'h50), 0, 4, 1, "R10 request while busy");
    summary();
  end

endmodule